// File: doc/BRIEF.md
# Element-Width Saturating Clamp Stage

This stage takes a 64-bit signed intermediate integer result and fits it into a narrower element. A 2-bit width code picks the element size. One bit picks signed or unsigned limits, and another bit turns saturation on. With saturation on, a value outside the element's range is pinned to the nearest limit, and a flag reports that the value was clamped. With saturation off, the bits above the element width are dropped and the result wraps.

Each result is zero-extended or sign-extended back to 64 bits, following the signedness bit. The stage is registered, so an input accepted on one clock edge shows up on the outputs after that edge, together with its own saturation flag. A vector datapath drives one element per cycle through it, and may change the width code, signedness and saturate-enable on every element.

Top module: `elw_clamp_stage`

## Requirements
- R1: While reset is asserted (`rst_n` low), `out_valid`, `out_sat` and `out_value` are all zero.
- R2: An input presented with `in_valid` high on a rising edge appears on `out_valid`, `out_value` and `out_sat` immediately after that edge, with one cycle of latency. Back-to-back inputs produce back-to-back outputs.
- R3: The width code `in_width` selects the element size: 2'b01 gives 8 bits, 2'b10 gives 16 bits, 2'b11 gives 32 bits, and 2'b00 gives the native 64 bits.
- R4: With `in_sat_en`=1 and `in_signed`=0, an input greater than 2^w-1 produces 2^w-1 (zero-extended) and sets `out_sat`.
- R5: With `in_sat_en`=1 and `in_signed`=0, a negative input produces zero and sets `out_sat`.
- R6: With `in_sat_en`=1 and `in_signed`=1, an input above 2^(w-1)-1 produces that maximum, and an input below -2^(w-1) produces that minimum. Both are sign-extended to 64 bits, and both set `out_sat`.
- R7: With `in_sat_en`=1, an input inside the selected range passes through unchanged with `out_sat`=0. This includes the two limits themselves.
- R8: With `in_sat_en`=0, the output keeps the low w bits of the input. It is zero-extended when `in_signed`=0 and sign-extended when `in_signed`=1. `out_sat` stays 0 even when the input is out of range.
- R9: After a cycle with `in_valid` low, `out_valid` and `out_sat` are 0, and `out_value` keeps its previous value.
- R10: At the native 64-bit width, a signed clamp never saturates. An unsigned clamp saturates only negative inputs, which go to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input element strobe |
| in_value | input | 64 | Signed intermediate result |
| in_width | input | 2 | Element width code |
| in_sat_en | input | 1 | 1 = saturate, 0 = wrap |
| in_signed | input | 1 | 1 = signed limits and sign extension |
| out_valid | output | 1 | Output element strobe |
| out_value | output | 64 | Clamped or wrapped element, extended to 64 bits |
| out_sat | output | 1 | Element was clamped |

## Verification
The value path and the flag path act on the same element in the same cycle. Wrapping and saturating elements can also follow each other with no gap. The risk is that a flag lands on the wrong element, or that the wrong limit is applied when the mode changes between neighbours. The bench streams elements back to back and changes width, signedness and saturate-enable on every element. It places exact-limit values, one-past-limit values and wrapped out-of-range values next to each other. Every output cycle is compared, for both value and flag, against a bench model that uses 128-bit arithmetic.

// File: rtl/elw_clamp_pkg.sv
package elw_clamp_pkg;

  typedef enum logic [1:0] {
    EW_NATIVE = 2'b00,
    EW_BYTE   = 2'b01,
    EW_HALF   = 2'b10,
    EW_WORD   = 2'b11
  } elw_code_e;

  localparam int unsigned NUM_CODES = 4;

  // Element width selected by a code; the native code maps to the datapath width.
  function automatic int unsigned code_bits(input int unsigned code, input int unsigned dw,
                                            input int unsigned w_b, input int unsigned w_h,
                                            input int unsigned w_w);
    case (code)
      1:       return w_b;
      2:       return w_h;
      3:       return w_w;
      default: return dw;
    endcase
  endfunction

endpackage

// File: rtl/elw_limit_gen.sv
module elw_limit_gen
  import elw_clamp_pkg::*;
#(
  parameter int unsigned DW   = 64,
  parameter int unsigned W_B  = 8,
  parameter int unsigned W_H  = 16,
  parameter int unsigned W_W  = 32
) (
  input  logic [1:0]    code,
  input  logic          is_signed,
  output logic [DW-1:0] keep_mask,
  output logic [DW-1:0] sign_mask,
  output logic [DW:0]   hi_lim,
  output logic [DW:0]   lo_lim
);

  logic [DW-1:0] mask_tab [NUM_CODES];

  // One constant mask per width code.
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_mask
    localparam int unsigned EW = code_bits(g, DW, W_B, W_H, W_W);
    assign mask_tab[g] = {DW{1'b1}} >> (DW - EW);
  end

  logic [DW-1:0] half_mask;

  always_comb begin
    keep_mask = mask_tab[code];
    half_mask = keep_mask >> 1;
    sign_mask = keep_mask ^ half_mask;
    if (is_signed) begin
      hi_lim = {1'b0, half_mask};
      lo_lim = {1'b1, ~half_mask};
    end else begin
      hi_lim = {1'b0, keep_mask};
      lo_lim = '0;
    end
  end

endmodule

// File: rtl/elw_range_detect.sv
module elw_range_detect #(
  parameter int unsigned DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] value,
  input  logic [DW:0]   hi_lim,
  input  logic [DW:0]   lo_lim,
  output logic          above,
  output logic          below
);

  logic signed [DW:0] value_ext;

  always_comb begin
    value_ext = $signed({value[DW-1], value});
    above     = value_ext > $signed(hi_lim);
    below     = value_ext < $signed(lo_lim);
  end

  AST_RANGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(above && below)); // R7

  AST_LIMIT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    $signed(lo_lim) <= $signed(hi_lim)); // R3

endmodule

// File: rtl/elw_wrap_ext.sv
module elw_wrap_ext #(
  parameter int unsigned DW = 64
) (
  input  logic [DW-1:0] value,
  input  logic [DW-1:0] keep_mask,
  input  logic [DW-1:0] sign_mask,
  input  logic          is_signed,
  output logic [DW-1:0] wrapped
);

  logic [DW-1:0] low_bits;
  logic          top_bit;

  always_comb begin
    low_bits = value & keep_mask;
    top_bit  = |(value & sign_mask);
    wrapped  = (is_signed && top_bit) ? (low_bits | ~keep_mask) : low_bits;
  end

endmodule

// File: rtl/elw_clamp_stage.sv
module elw_clamp_stage
  import elw_clamp_pkg::*;
#(
  parameter int unsigned DW  = 64,
  parameter int unsigned W_B = 8,
  parameter int unsigned W_H = 16,
  parameter int unsigned W_W = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_value,
  input  logic [1:0]    in_width,
  input  logic          in_sat_en,
  input  logic          in_signed,
  output logic          out_valid,
  output logic [DW-1:0] out_value,
  output logic          out_sat
);

  logic [DW-1:0] keep_mask;
  logic [DW-1:0] sign_mask;
  logic [DW:0]   hi_lim;
  logic [DW:0]   lo_lim;
  logic          above;
  logic          below;
  logic [DW-1:0] wrapped;
  logic [DW-1:0] next_value;
  logic          sat_event;

  elw_limit_gen #(.DW(DW), .W_B(W_B), .W_H(W_H), .W_W(W_W)) u_limits (
    .code      (in_width),
    .is_signed (in_signed),
    .keep_mask (keep_mask),
    .sign_mask (sign_mask),
    .hi_lim    (hi_lim),
    .lo_lim    (lo_lim)
  );

  elw_range_detect #(.DW(DW)) u_range (
    .clk    (clk),
    .rst_n  (rst_n),
    .value  (in_value),
    .hi_lim (hi_lim),
    .lo_lim (lo_lim),
    .above  (above),
    .below  (below)
  );

  elw_wrap_ext #(.DW(DW)) u_wrap (
    .value     (in_value),
    .keep_mask (keep_mask),
    .sign_mask (sign_mask),
    .is_signed (in_signed),
    .wrapped   (wrapped)
  );

  always_comb begin
    sat_event = in_sat_en && (above || below);
    if (in_sat_en && above)      next_value = hi_lim[DW-1:0];
    else if (in_sat_en && below) next_value = lo_lim[DW-1:0];
    else                         next_value = wrapped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_value <= '0;
      out_sat   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      out_sat   <= in_valid && sat_event;
      if (in_valid) out_value <= next_value;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_sat)); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_value)); // R9

  AST_NO_SAT_WITHOUT_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_sat_en) |=> !out_sat); // R8

  AST_UNSIGNED_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_signed) |-> ((next_value & ~keep_mask) == '0)); // R4

  AST_SIGNED_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_signed) |->
      ((next_value & ~keep_mask) == ((|(next_value & sign_mask)) ? ~keep_mask : '0))); // R6

endmodule

// File: tb/sim_elw_clamp_stage.sv
`timescale 1ns/1ps
module sim_elw_clamp_stage;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_value;
  logic [1:0]  in_width;
  logic        in_sat_en;
  logic        in_signed;
  logic        out_valid;
  logic [63:0] out_value;
  logic        out_sat;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  elw_clamp_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_value(in_value),
    .in_width(in_width), .in_sat_en(in_sat_en), .in_signed(in_signed),
    .out_valid(out_valid), .out_value(out_value), .out_sat(out_sat)
  );

  function automatic int width_of(input logic [1:0] c);
    case (c)
      2'b01: return 8;
      2'b10: return 16;
      2'b11: return 32;
      default: return 64;
    endcase
  endfunction

  // Reference model in 128-bit signed arithmetic.
  function automatic logic [64:0] model(input logic [63:0] v, input logic [1:0] c,
                                        input logic sat, input logic n);
    logic signed [127:0] x, hi, lo, r, m;
    int w;
    logic flag;
    w = width_of(c);
    x = {{64{v[63]}}, v};
    m = (128'sd1 <<< w);
    if (n) begin
      hi = (128'sd1 <<< (w - 1)) - 1;
      lo = -(128'sd1 <<< (w - 1));
    end else begin
      hi = m - 1;
      lo = 0;
    end
    flag = 1'b0;
    if (sat && x > hi) begin r = hi; flag = 1'b1; end
    else if (sat && x < lo) begin r = lo; flag = 1'b1; end
    else begin
      r = x & (m - 1);
      if (n && r >= (128'sd1 <<< (w - 1))) r = r - m;
    end
    return {flag, r[63:0]};
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send(input string tag, input logic [63:0] v, input logic [1:0] c,
                      input logic sat, input logic n);
    logic [64:0] e;
    e = model(v, c, sat, n);
    @(negedge clk);
    in_valid = 1'b1; in_value = v; in_width = c; in_sat_en = sat; in_signed = n;
    @(posedge clk);
    #2;
    check(tag, "valid", {63'd0, out_valid}, 64'd1);
    check(tag, "value", out_value, e[63:0]);
    check(tag, "sat",   {63'd0, out_sat}, {63'd0, e[64]});
  endtask

  task automatic idle(input string tag, input logic [63:0] held);
    @(negedge clk);
    in_valid = 1'b0; in_value = 64'hDEAD_BEEF_0BAD_F00D; in_sat_en = 1'b1;
    @(posedge clk);
    #2;
    check(tag, "idle valid", {63'd0, out_valid}, 64'd0);
    check(tag, "idle sat",   {63'd0, out_sat}, 64'd0);
    check(tag, "idle hold",  out_value, held);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b1; in_value = 64'hFFFF; in_width = 2'b01;
    in_sat_en = 1'b1; in_signed = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R1", "reset valid", {63'd0, out_valid}, 64'd0);
    check("R1", "reset sat",   {63'd0, out_sat}, 64'd0);
    check("R1", "reset value", out_value, 64'd0);
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b1;
  endtask

  task automatic t_width_codes;
    send("R3", 64'h1234_5678_9ABC_DEF0, 2'b01, 1'b0, 1'b0);
    send("R3", 64'h1234_5678_9ABC_DEF0, 2'b10, 1'b0, 1'b0);
    send("R3", 64'h1234_5678_9ABC_DEF0, 2'b11, 1'b0, 1'b0);
    send("R3", 64'h1234_5678_9ABC_DEF0, 2'b00, 1'b0, 1'b0);
  endtask

  task automatic t_unsigned_sat;
    send("R4", 64'd256,        2'b01, 1'b1, 1'b0);
    send("R4", 64'd70000,      2'b10, 1'b1, 1'b0);
    send("R4", 64'h1_0000_0000, 2'b11, 1'b1, 1'b0);
  endtask

  task automatic t_unsigned_neg;
    send("R5", -64'sd1,   2'b01, 1'b1, 1'b0);
    send("R5", -64'sd500, 2'b11, 1'b1, 1'b0);
  endtask

  task automatic t_signed_sat;
    send("R6", 64'd128,     2'b01, 1'b1, 1'b1);
    send("R6", -64'sd129,   2'b01, 1'b1, 1'b1);
    send("R6", 64'd40000,   2'b10, 1'b1, 1'b1);
    send("R6", -64'sd40000, 2'b10, 1'b1, 1'b1);
    send("R6", 64'h8000_0000, 2'b11, 1'b1, 1'b1);
  endtask

  task automatic t_boundaries;
    send("R7", 64'd255,       2'b01, 1'b1, 1'b0);
    send("R7", 64'd0,         2'b10, 1'b1, 1'b0);
    send("R7", 64'd127,       2'b01, 1'b1, 1'b1);
    send("R7", -64'sd128,     2'b01, 1'b1, 1'b1);
    send("R7", 64'h7FFF_FFFF, 2'b11, 1'b1, 1'b1);
    send("R7", -64'sd2147483648, 2'b11, 1'b1, 1'b1);
  endtask

  task automatic t_wrap;
    send("R8", 64'h1FF,   2'b01, 1'b0, 1'b0);
    send("R8", 64'h1FF,   2'b01, 1'b0, 1'b1);
    send("R8", 64'h1_8001, 2'b10, 1'b0, 1'b1);
    send("R8", -64'sd1,   2'b11, 1'b0, 1'b0);
  endtask

  task automatic t_idle_hold;
    send("R9", 64'd300, 2'b01, 1'b1, 1'b0);
    idle("R9", 64'd255);
    idle("R9", 64'd255);
  endtask

  task automatic t_native;
    send("R10", 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b1);
    send("R10", 64'h8000_0000_0000_0000, 2'b00, 1'b1, 1'b1);
    send("R10", 64'h8000_0000_0000_0000, 2'b00, 1'b1, 1'b0);
    send("R10", 64'h7FFF_FFFF_FFFF_FFFF, 2'b00, 1'b1, 1'b0);
  endtask

  // Back-to-back mixed modes: flag must stay with its own element.
  task automatic t_stream;
    send("R2", 64'd1000, 2'b01, 1'b1, 1'b1);
    send("R2", 64'd1000, 2'b01, 1'b0, 1'b1);
    send("R2", 64'd127,  2'b01, 1'b1, 1'b1);
    send("R2", -64'sd1,  2'b10, 1'b1, 1'b0);
    send("R2", -64'sd1,  2'b10, 1'b1, 1'b1);
    send("R2", 64'd65536, 2'b10, 1'b0, 1'b0);
    send("R2", 64'd65536, 2'b10, 1'b1, 1'b0);
  endtask

  initial begin
    t_reset();
    t_width_codes();
    t_unsigned_sat();
    t_unsigned_neg();
    t_signed_sat();
    t_boundaries();
    t_wrap();
    t_idle_hold();
    t_native();
    t_stream();
    idle("R9", 64'd65535);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_600_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule